// File: doc/BRIEF.md
# Type-2 Angle Tracking Loop

This block refines a shaft angle measured once per excitation period into a high-resolution angle and a speed estimate. Each new measured angle arrives with a one-cycle strobe. The block compares it with the loop's own angle from the previous update, and that one-update delay matches the group delay of the demodulation filter ahead of it. The difference drives an incremental PI controller. A first-order IIR lowpass smooths the PI output, and the smoothed value is the speed. An integrator accumulates the speed into the angle. The loop has two integrators, so at constant speed the error settles to zero. At that point the undelayed tracked angle leads the measurement by one update and shows no velocity lag.

Angles are unsigned 16-bit values. 0x0000 is 0 degrees, 0x8000 is 180 degrees, and the full code range is one revolution. The PI gains are signed Q15 values. The IIR coefficients are signed values with 15 fraction bits and three integer bits including the sign. The speed is a signed value in angle LSB per update, with 15 fraction bits.

Top module: `angle_tracker`

## Requirements
- R1: While reset is high, the next clock edge clears angle_o and speed_o to zero.
- R2: The first strobed sample after reset loads its angle directly into angle_o on the edge that samples the strobe. speed_o stays zero whatever the gains are.
- R3: On every edge where the strobe is low, angle_o and speed_o keep their values, even if the other inputs change.
- R4: In later updates the error is meas_angle_i minus the current angle_o, taken modulo 2^16 as a signed 16-bit value. For example, 0x0010 against 0xFFF0 gives +32.
- R5: The PI state updates as u(n) = u(n-1) + (KP+KI)·e(n) − KP·e(n-1). The gains are Q15 values, u carries 15 fraction bits, and e(n-1) is zero before the first PI update.
- R6: The speed updates as y(n) = (a0·u(n) + a1·u(n-1) + b1·y(n-1)) >>> 15, an arithmetic shift. speed_o equals y.
- R7: The angle accumulator holds 16 integer and 15 fraction bits. It adds y modulo 2^31, and angle_o is its upper 16 bits.
- R8: u and y saturate at +(2^39−1) and −2^39 and never wrap.
- R9: With KP and KI both zero, updates after the first leave angle_o and speed_o unchanged.
- R10: With unity IIR (a0 = 32768, a1 = b1 = 0) and a measured angle that ramps at a constant step, the loop settles. angle_o then equals the next measured angle within 2 LSB, including across the 0/360 degree crossing, and speed_o >>> 15 equals the step within 2.
- R11: Outputs change only on the clock edge that samples the strobe. They do not change earlier in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| meas_valid_i | input | 1 | One-cycle strobe for a new measured angle |
| meas_angle_i | input | 16 | Measured angle, one revolution full scale |
| kp_i | input | 16 | Proportional gain, signed Q15 |
| ki_i | input | 16 | Integral gain, signed Q15 |
| a0_i | input | 18 | IIR feed-forward coefficient on u(n), signed, 15 fraction bits |
| a1_i | input | 18 | IIR feed-forward coefficient on u(n-1), signed, 15 fraction bits |
| b1_i | input | 18 | IIR feedback coefficient on y(n-1), signed, 15 fraction bits |
| angle_o | output | 16 | Tracked angle |
| speed_o | output | 40 | Speed estimate, signed, 15 fraction bits |

## Verification
The bench targets wrap handling in two places. One is an error that spans the 0/360 crossing: an unwrapped subtraction would show a near-full-revolution error and a huge speed kick. The other is ramps that cross zero repeatedly, where a design with a wrong lag would settle one update behind the measurement. It also drives the PI state to both rails with a constant half-revolution error. A non-saturating accumulator would flip sign there and send the speed in the opposite direction. Other tests cover:
- the first-sample load, where a design that runs the loop instead would report a nonzero speed;
- zero gains, where a leaky state would drift the angle;
- an update-by-update comparison of all states against a fixed-point reference model, which catches swapped IIR taps, a wrong e(n-1) or a wrong shift.

// File: rtl/ang_trk_pkg.sv
package ang_trk_pkg;
  // Loop phase: waiting for the first measurement, or tracking.
  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_RUN  = 1'b1
  } trk_state_e;
endpackage

// File: rtl/ang_trk_pi.sv
// Incremental PI stage with saturating state.
module ang_trk_pi #(
  parameter int GAIN_W = 16,
  parameter int ERR_W  = 16,
  parameter int ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_i,
  input  logic signed [GAIN_W-1:0] kp_i,
  input  logic signed [GAIN_W-1:0] ki_i,
  input  logic signed [ERR_W-1:0]  err_i,
  output logic signed [ACC_W-1:0]  u_next_o,
  output logic signed [ACC_W-1:0]  u_q_o
);
  localparam int PROD_W = GAIN_W + 1 + ERR_W;
  localparam int DEL_W  = PROD_W + 1;
  localparam int SUM_W  = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] SAT_HI = {{3{1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SAT_LO = {{3{1'b1}}, {(ACC_W-1){1'b0}}};

  logic signed [GAIN_W:0]    ksum;
  logic signed [PROD_W-1:0]  p_now, p_old;
  logic signed [DEL_W-1:0]   delta;
  logic signed [SUM_W-1:0]   sum;
  logic signed [ERR_W-1:0]   e_prev_q;
  logic signed [ACC_W-1:0]   u_q;

  assign ksum  = {kp_i[GAIN_W-1], kp_i} + {ki_i[GAIN_W-1], ki_i};
  assign p_now = PROD_W'(ksum) * PROD_W'(err_i);
  assign p_old = PROD_W'(kp_i) * PROD_W'(e_prev_q);
  assign delta = DEL_W'(p_now) - DEL_W'(p_old);
  assign sum   = SUM_W'(u_q) + SUM_W'(delta);

  always_comb begin
    if (sum > SAT_HI)      u_next_o = SAT_HI[ACC_W-1:0];
    else if (sum < SAT_LO) u_next_o = SAT_LO[ACC_W-1:0];
    else                   u_next_o = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u_q      <= '0;
      e_prev_q <= '0;
    end else if (en_i) begin
      u_q      <= u_next_o;
      e_prev_q <= err_i;
    end
  end

  assign u_q_o = u_q;

  // R8: a positive increment never lowers the state (no wrap to negative)
  assert_pi_no_wrap_up_R8: assert property (@(posedge clk) disable iff (rst)
    (en_i && delta > 0) |=> (u_q >= $past(u_q)));
  // R8: a negative increment never raises the state
  assert_pi_no_wrap_dn_R8: assert property (@(posedge clk) disable iff (rst)
    (en_i && delta < 0) |=> (u_q <= $past(u_q)));
  // R9: zero gains freeze the controller state
  assert_pi_zero_gain_R9: assert property (@(posedge clk) disable iff (rst)
    (en_i && kp_i == '0 && ki_i == '0) |=> $stable(u_q));
endmodule

// File: rtl/ang_trk_iir.sv
// First-order IIR lowpass producing the speed estimate, saturating.
module ang_trk_iir #(
  parameter int COEF_W = 18,
  parameter int FRAC   = 15,
  parameter int ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_i,
  input  logic signed [COEF_W-1:0] a0_i,
  input  logic signed [COEF_W-1:0] a1_i,
  input  logic signed [COEF_W-1:0] b1_i,
  input  logic signed [ACC_W-1:0]  u_cur_i,
  input  logic signed [ACC_W-1:0]  u_old_i,
  output logic signed [ACC_W-1:0]  y_next_o,
  output logic signed [ACC_W-1:0]  y_q_o
);
  localparam int MP_W  = ACC_W + COEF_W;
  localparam int SUM_W = MP_W + 2;
  localparam int PAD_W = SUM_W - ACC_W + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI = {{PAD_W{1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SAT_LO = {{PAD_W{1'b1}}, {(ACC_W-1){1'b0}}};
  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1) <<< FRAC;

  logic signed [MP_W-1:0]  m_cur, m_old, m_fb;
  logic signed [SUM_W-1:0] sum, scaled;
  logic signed [ACC_W-1:0] y_q;

  assign m_cur  = MP_W'(a0_i) * MP_W'(u_cur_i);
  assign m_old  = MP_W'(a1_i) * MP_W'(u_old_i);
  assign m_fb   = MP_W'(b1_i) * MP_W'(y_q);
  assign sum    = SUM_W'(m_cur) + SUM_W'(m_old) + SUM_W'(m_fb);
  assign scaled = sum >>> FRAC;

  always_comb begin
    if (scaled > SAT_HI)      y_next_o = SAT_HI[ACC_W-1:0];
    else if (scaled < SAT_LO) y_next_o = SAT_LO[ACC_W-1:0];
    else                      y_next_o = scaled[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       y_q <= '0;
    else if (en_i) y_q <= y_next_o;
  end

  assign y_q_o = y_q;

  // R6: with unity pass-through coefficients the speed copies the PI output
  assert_iir_unity_R6: assert property (@(posedge clk) disable iff (rst)
    (en_i && a0_i == UNITY && a1_i == '0 && b1_i == '0) |=> (y_q == $past(u_cur_i)));
endmodule

// File: rtl/ang_trk_integ.sv
// Wrapping fixed-point angle integrator with direct load.
module ang_trk_integ #(
  parameter int ANG_W = 16,
  parameter int FRAC  = 15,
  parameter int ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_i,
  input  logic [ANG_W-1:0]        load_val_i,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] step_i,
  output logic [ANG_W-1:0]        angle_o
);
  localparam int POS_W = ANG_W + FRAC;

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst)         pos_q <= '0;
    else if (load_i) pos_q <= {load_val_i, {FRAC{1'b0}}};
    else if (en_i)   pos_q <= pos_q + step_i[POS_W-1:0];
  end

  assign angle_o = pos_q[POS_W-1 -: ANG_W];

  // R7: a zero step leaves the accumulator untouched
  assert_integ_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (en_i && !load_i && step_i == '0) |=> $stable(pos_q));
endmodule

// File: rtl/angle_tracker.sv
module angle_tracker #(
  parameter int ANG_W  = 16,
  parameter int GAIN_W = 16,
  parameter int COEF_W = 18,
  parameter int FRAC   = 15,
  parameter int ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     meas_valid_i,
  input  logic [ANG_W-1:0]         meas_angle_i,
  input  logic signed [GAIN_W-1:0] kp_i,
  input  logic signed [GAIN_W-1:0] ki_i,
  input  logic signed [COEF_W-1:0] a0_i,
  input  logic signed [COEF_W-1:0] a1_i,
  input  logic signed [COEF_W-1:0] b1_i,
  output logic [ANG_W-1:0]         angle_o,
  output logic signed [ACC_W-1:0]  speed_o
);
  import ang_trk_pkg::*;

  trk_state_e              state_q;
  logic                    load, run;
  logic signed [ANG_W-1:0] err;
  logic signed [ACC_W-1:0] u_next, u_q, y_next, y_q;

  always_ff @(posedge clk) begin
    if (rst)                                     state_q <= TRK_IDLE;
    else if (meas_valid_i && state_q == TRK_IDLE) state_q <= TRK_RUN;
  end

  assign load = meas_valid_i && (state_q == TRK_IDLE);
  assign run  = meas_valid_i && (state_q == TRK_RUN);
  // Wrapped error against the previous tracked angle (one-update delay)
  assign err  = meas_angle_i - angle_o;

  ang_trk_pi #(.GAIN_W(GAIN_W), .ERR_W(ANG_W), .ACC_W(ACC_W)) pi_i (
    .clk(clk), .rst(rst), .en_i(run), .kp_i(kp_i), .ki_i(ki_i),
    .err_i(err), .u_next_o(u_next), .u_q_o(u_q));

  ang_trk_iir #(.COEF_W(COEF_W), .FRAC(FRAC), .ACC_W(ACC_W)) iir_i (
    .clk(clk), .rst(rst), .en_i(run), .a0_i(a0_i), .a1_i(a1_i), .b1_i(b1_i),
    .u_cur_i(u_next), .u_old_i(u_q), .y_next_o(y_next), .y_q_o(y_q));

  ang_trk_integ #(.ANG_W(ANG_W), .FRAC(FRAC), .ACC_W(ACC_W)) integ_i (
    .clk(clk), .rst(rst), .load_i(load), .load_val_i(meas_angle_i),
    .en_i(run), .step_i(y_next), .angle_o(angle_o));

  assign speed_o = y_q;

  // R1: reset clears both outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (angle_o == '0 && speed_o == '0));
  // R2: first sample loads the angle, speed stays zero
  assert_first_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (angle_o == $past(meas_angle_i) && speed_o == '0));
  // R3: no strobe, no change
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !meas_valid_i |=> ($stable(angle_o) && $stable(speed_o)));
endmodule

// File: tb/angle_tracker_tb_top.sv
module angle_tracker_tb_top;
  localparam longint SAT_HI  = (longint'(1) <<< 39) - 1;
  localparam longint SAT_LO  = -(longint'(1) <<< 39);
  localparam longint POS_MSK = (longint'(1) <<< 31) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid = 1'b0;
  logic [15:0] meas = '0;
  logic signed [15:0] kp = '0, ki = '0;
  logic signed [17:0] a0 = '0, a1 = '0, b1 = '0;
  logic [15:0] angle_o;
  logic signed [39:0] speed_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference model state
  bit m_init;
  longint m_pos, m_u, m_y, m_ep;

  always #2.5 clk = ~clk;

  angle_tracker dut_i (
    .clk(clk), .rst(rst), .meas_valid_i(valid), .meas_angle_i(meas),
    .kp_i(kp), .ki_i(ki), .a0_i(a0), .a1_i(a1), .b1_i(b1),
    .angle_o(angle_o), .speed_o(speed_o));

  function automatic longint sat(input longint v);
    if (v > SAT_HI) return SAT_HI;
    if (v < SAT_LO) return SAT_LO;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(input longint mv);
    longint d, un, yn;
    if (!m_init) begin
      m_init = 1'b1;
      m_pos  = mv <<< 15;
      return;
    end
    d = (mv - (m_pos >>> 15)) & 65535;
    if (d >= 32768) d -= 65536;
    un = sat(m_u + (longint'(kp) + longint'(ki)) * d - longint'(kp) * m_ep);
    yn = sat((longint'(a0) * un + longint'(a1) * m_u + longint'(b1) * m_y) >>> 15);
    m_pos = (m_pos + yn) & POS_MSK;
    m_u = un; m_y = yn; m_ep = d;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_init = 1'b0; m_pos = 0; m_u = 0; m_y = 0; m_ep = 0;
  endtask

  task automatic update(input logic [15:0] mv);
    @(negedge clk); valid = 1'b1; meas = mv;
    @(negedge clk); valid = 1'b0;
    model_step(longint'(mv));
  endtask

  task automatic cmp_model(input string req);
    chk(longint'(angle_o) == (m_pos >>> 15), {req, " angle"}, longint'(angle_o), m_pos >>> 15);
    chk(longint'(speed_o) == m_y, {req, " speed"}, longint'(speed_o), m_y);
  endtask

  task automatic set_coef(input int p, input int i, input int c0, input int c1, input int c2);
    kp = 16'(p); ki = 16'(i); a0 = 18'(c0); a1 = 18'(c1); b1 = 18'(c2);
  endtask

  // R1 reset state
  task automatic t_reset();
    do_reset();
    chk(angle_o == 16'h0, "R1 angle", angle_o, 0);
    chk(speed_o == 40'sd0, "R1 speed", speed_o, 0);
  endtask

  // R2, R11, R3: first load, edge timing and hold
  task automatic t_first_load();
    set_coef(9830, 851, 32768, 0, 0);
    do_reset();
    @(negedge clk); valid = 1'b1; meas = 16'h1234;
    #1;
    chk(angle_o == 16'h0, "R11 no early change", angle_o, 0);
    @(negedge clk); valid = 1'b0;
    model_step(64'h1234);
    chk(angle_o == 16'h1234, "R2 angle load", angle_o, 16'h1234);
    chk(speed_o == 40'sd0, "R2 speed zero", speed_o, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); meas = 16'(k * 4099 + 7); kp = 16'(k * 1000);
    end
    chk(angle_o == 16'h1234, "R3 angle hold", angle_o, 16'h1234);
    chk(speed_o == 40'sd0, "R3 speed hold", speed_o, 0);
  endtask

  // R4, R5: hand-computed PI step including wrap
  task automatic t_pi_step();
    set_coef(9830, 851, 32768, 0, 0);
    do_reset();
    update(16'h1000);
    update(16'h1800);
    chk(speed_o == 40'sd21874688, "R5 first step speed", speed_o, 21874688);
    chk(angle_o == 16'd4763, "R5 first step angle", angle_o, 4763);
    for (int k = 0; k < 20; k++) begin
      update(16'h1800);
      cmp_model("R5 step model");
    end
    do_reset();
    update(16'hFFF0);
    update(16'h0010);
    chk(speed_o == 40'sd341792, "R4 wrapped error", speed_o, 341792);
  endtask

  // R9: zero gains
  task automatic t_zero_gain();
    set_coef(0, 0, 32768, 0, 0);
    do_reset();
    update(16'h4000);
    for (int k = 0; k < 6; k++) begin
      update(16'(k * 9000 + 123));
      chk(angle_o == 16'h4000, "R9 angle frozen", angle_o, 16'h4000);
      chk(speed_o == 40'sd0, "R9 speed frozen", speed_o, 0);
    end
  endtask

  // R6: full IIR against model
  task automatic t_iir();
    set_coef(3276, 163, 8192, 8192, 16384);
    do_reset();
    update(16'h0100);
    for (int k = 1; k < 60; k++) begin
      update(16'(16'h0100 + k * 150));
      cmp_model("R6 iir model");
    end
  endtask

  // R7, R10: ramps across the wrap, settling with no lag
  task automatic t_ramp(input int start, input int step, input int p, input int i, input int n, input string tag);
    longint mv, nxt, diff;
    set_coef(p, i, 32768, 0, 0);
    do_reset();
    mv = longint'(start);
    for (int k = 0; k < n; k++) begin
      update(16'(mv));
      cmp_model("R7 integ model");
      mv = (mv + step) & 65535;
    end
    nxt = mv;
    diff = (longint'(angle_o) - nxt) & 65535;
    if (diff >= 32768) diff -= 65536;
    chk(diff <= 2 && diff >= -2, {tag, " no lag"}, angle_o, nxt);
    diff = (longint'(speed_o) >>> 15) - step;
    chk(diff <= 2 && diff >= -2, {tag, " speed"}, longint'(speed_o) >>> 15, step);
  endtask

  // R8: saturation at both rails
  task automatic t_sat();
    bit neg_seen;
    set_coef(0, 32767, 32768, 0, 0);
    do_reset();
    update(16'h0000);
    neg_seen = 1'b0;
    for (int k = 0; k < 600; k++) begin
      update(angle_o + 16'h7FFF);
      if (speed_o < 0) neg_seen = 1'b1;
    end
    chk(!neg_seen, "R8 no wrap up", neg_seen, 0);
    chk(longint'(speed_o) == SAT_HI, "R8 upper rail", speed_o, SAT_HI);
    cmp_model("R8 model up");
    for (int k = 0; k < 1100; k++) update(angle_o + 16'h8000);
    chk(longint'(speed_o) == SAT_LO, "R8 lower rail", speed_o, SAT_LO);
    cmp_model("R8 model down");
  endtask

  initial begin
    t_reset();
    t_first_load();
    t_pi_step();
    t_zero_gain();
    t_iir();
    t_ramp(16'hF000, 300, 9830, 851, 400, "R10 fast");
    t_ramp(16'h0200, -523, 1638, 32, 900, "R10 slow");
    t_sat();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule